// File: doc/BRIEF.md
# Bit-Stuffed Infrared Frame Transmitter

This block assembles serial infrared frames from bytes delivered by a transmit buffer over a valid/ready handshake. Each frame is sent as a bit stream, one NRZ bit per bit-strobe pulse, to a line encoder downstream. The stream is built in this order:
- a pair of opening flags;
- an address byte;
- an optional control byte;
- any whole number of data bytes;
- a 16-bit frame check sequence;
- one closing flag.

Stuffed zeros keep the flag pattern unique inside the frame. The bytes carry no length field: the frame ends at the byte that carries the end-of-frame marker.

When the buffer has no byte ready at a byte boundary inside a frame, the frame cannot be completed. The transmitter aborts it by sending a run of ones and returns to idle. It raises a one-cycle interrupt and sets an underrun status bit, which stays set until software writes a one to clear it. The enable input gates only the acceptance of bytes and the start of a new frame.

Top module: `irtx_framer`

## Requirements
- R1: After reset, `tx_bit` is 1, `tx_frame` is 0, `underrun` and `irq` are 0, and the byte holding stage is empty. Whenever `tx_frame` is 0 the line bit is 1.
- R2: While `enable` is 0, `in_ready` stays 0, no byte is taken and no frame starts, even with `in_valid` held at 1.
- R3: A frame starts at a strobe once a byte is held and `enable` is 1. Each strobe emits one bit. The first 16 bits are two flags of pattern 01111110, and every byte goes out least significant bit first.
- R4: The fields follow the byte order of the handshake. The first byte is the address. When `ctrl_present` is 1 (sampled at frame start) the second byte is the control field. Data bytes follow, up to the byte that carries `in_last`.
- R5: After the last byte comes the ones complement of a CRC, sent least significant bit first (low byte first). The CRC uses polynomial x^16+x^12+x^5+1, is preset to all ones and covers the field bits only, not stuffed zeros. Its bit-serial form is reflected: feedback = crc[0] xor bit, shift right, xor 0x8408 when the feedback is 1.
- R6: A 0 is inserted after every five consecutive ones among the field and check bits, including just before the closing flag. Flag bits are never stuffed.
- R7: One closing flag 01111110 follows the check sequence. Then the line returns to 1 and `tx_frame` falls.
- R8: With `ctrl_present` = 1, an `in_last` marker on the address byte is disregarded, and the frame continues with a control byte.
- R9: A frame may hold just the address byte (`ctrl_present` = 0 and `in_last` on the first byte).
- R10: If no byte is held when the current non-final byte finishes, the frame aborts. Eight ones follow at once, with no check sequence and no closing flag, and then the line is idle. `irq` pulses high for exactly one clock, and completed frames never raise it.
- R11: `underrun` goes to 1 on an abort and stays at 1 until a cycle with `clr_underrun` = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows bytes to be taken and frames to start |
| ctrl_present | input | 1 | Second byte is a control field; sampled at frame start |
| in_data | input | 8 | Byte from the transmit buffer |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | `in_data` is the last byte of the frame |
| in_ready | output | 1 | Byte is taken at this clock edge when `in_valid` is 1 |
| bit_strobe | input | 1 | One-clock pulse per bit period |
| tx_bit | output | 1 | NRZ bit to the line encoder, updated at each strobe |
| tx_frame | output | 1 | Frame or abort sequence in progress |
| clr_underrun | input | 1 | Write-one-to-clear for `underrun` |
| underrun | output | 1 | Sticky underrun-abort status |
| irq | output | 1 | One-clock pulse when a frame is aborted |

## Verification
Every one of the 256 address values is sent as an address-only frame. This sweep exercises the check sequence for each byte value and the stuffing around every run of ones, including stuffing that falls at the end of the check sequence just before the closing flag. Multi-byte frames built from all-ones bytes, flag-valued bytes, zero bytes and a counting sequence separate stuffing that runs across byte boundaries from stuffing inside a byte. Frames with and without a control field, and a frame with an early end marker on its address byte, show whether the configuration bit changes the field sequence. A withheld byte after the address shows the abort tail apart from a normal close, together with the interrupt pulse, the sticky status and its clearing; a disabled window shows that no byte is taken.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int BYTE_W     = 8;
    localparam int FLAG_W     = 8;
    localparam int FCS_W      = 16;
    localparam int FLAG_IDX_W = $clog2(FLAG_W);

    localparam logic [FLAG_W-1:0] FLAG_PAT   = 8'h7E;
    localparam logic [FCS_W-1:0]  CRC_PRESET = 16'hFFFF;
    localparam logic [FCS_W-1:0]  CRC_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_BYTE,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } tx_byte_t;

    function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc_step = {1'b0, c[FCS_W-1:1]} ^ (fb ? CRC_POLY_R : '0);
    endfunction

endpackage

// File: rtl/irtx_feed.sv
module irtx_feed
    import irtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              take,
    output logic              hold_valid,
    output tx_byte_t          hold
);

    assign in_ready = enable && !hold_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold       <= '0;
        end else begin
            if (take) begin
                hold_valid <= 1'b0;
            end
            if (in_valid && in_ready) begin
                hold_valid <= 1'b1;
                hold.data  <= in_data;
                hold.last  <= in_last;
            end
        end
    end

endmodule

// File: rtl/irtx_crc.sv
module irtx_crc
    import irtx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic step,
    input  logic shift,
    input  logic bit_in,
    output logic fcs_bit
);

    logic [FCS_W-1:0] crc;

    assign fcs_bit = ~crc[0];

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= CRC_PRESET;
        end else if (step) begin
            crc <= crc_step(crc, bit_in);
        end else if (shift) begin
            crc <= {1'b1, crc[FCS_W-1:1]};
        end
    end

endmodule

// File: rtl/irtx_stuff.sv
module irtx_stuff #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    input  logic bit_in,
    output logic stuff_due
);

    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] ones;

    assign stuff_due = (ones == CW'(RUN));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ones <= '0;
        end else if (advance) begin
            ones <= bit_in ? ones + 1'b1 : '0;
        end
    end

endmodule

// File: rtl/irtx_framer.sv
module irtx_framer
    import irtx_pkg::*;
#(
    parameter int STUFF_RUN  = 5,
    parameter int ABORT_ONES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              ctrl_present,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              bit_strobe,
    output logic              tx_bit,
    output logic              tx_frame,
    input  logic              clr_underrun,
    output logic              underrun,
    output logic              irq
);

    localparam int CNT_MAX = (ABORT_ONES > 2 * FLAG_W) ? ABORT_ONES : 2 * FLAG_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    tx_state_e         st;
    logic [CNT_W-1:0]  bcnt;
    logic [BYTE_W-1:0] sh;
    logic              cur_last;
    logic              ctrl_q;

    logic     hold_valid;
    tx_byte_t hold;
    logic     take;
    logic     stuff_due, stuff_now, counted, field_bit;
    logic     fcs_bit;
    logic     byte_end, start;

    assign tx_frame  = (st != ST_IDLE);
    assign counted   = (st == ST_BYTE) || (st == ST_FCS);
    assign stuff_now = bit_strobe && stuff_due && (counted || st == ST_CLOSE);
    assign field_bit = (st == ST_BYTE) ? sh[0] : fcs_bit;
    assign byte_end  = bit_strobe && !stuff_now && (st == ST_BYTE) && (bcnt == CNT_W'(BYTE_W - 1));
    assign start     = bit_strobe && (st == ST_IDLE) && enable && hold_valid;
    assign take      = (bit_strobe && (st == ST_OPEN) && (bcnt == CNT_W'(2 * FLAG_W - 1)))
                     || (byte_end && !cur_last && hold_valid);

    irtx_feed u_feed (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .take       (take),
        .hold_valid (hold_valid),
        .hold       (hold)
    );

    irtx_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .init    (start),
        .step    (bit_strobe && !stuff_now && st == ST_BYTE),
        .shift   (bit_strobe && !stuff_now && st == ST_FCS),
        .bit_in  (sh[0]),
        .fcs_bit (fcs_bit)
    );

    irtx_stuff #(.RUN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst       (rst),
        .clear     (bit_strobe && (stuff_now || !counted)),
        .advance   (bit_strobe && counted),
        .bit_in    (field_bit),
        .stuff_due (stuff_due)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bcnt     <= '0;
            sh       <= '0;
            cur_last <= 1'b0;
            ctrl_q   <= 1'b0;
            tx_bit   <= 1'b1;
            underrun <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (clr_underrun) begin
                underrun <= 1'b0;
            end
            if (bit_strobe) begin
                case (st)
                    ST_IDLE: begin
                        tx_bit <= 1'b1;
                        if (start) begin
                            st     <= ST_OPEN;
                            tx_bit <= FLAG_PAT[0];
                            bcnt   <= CNT_W'(1);
                            ctrl_q <= ctrl_present;
                        end
                    end
                    ST_OPEN: begin
                        tx_bit <= FLAG_PAT[bcnt[FLAG_IDX_W-1:0]];
                        if (bcnt == CNT_W'(2 * FLAG_W - 1)) begin
                            st       <= ST_BYTE;
                            bcnt     <= '0;
                            sh       <= hold.data;
                            cur_last <= hold.last && !ctrl_q;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_BYTE: begin
                        if (stuff_now) begin
                            tx_bit <= 1'b0;
                        end else begin
                            tx_bit <= sh[0];
                            sh     <= sh >> 1;
                            bcnt   <= bcnt + 1'b1;
                            if (byte_end) begin
                                bcnt <= '0;
                                if (cur_last) begin
                                    st <= ST_FCS;
                                end else if (hold_valid) begin
                                    sh       <= hold.data;
                                    cur_last <= hold.last;
                                end else begin
                                    st       <= ST_ABORT;
                                    irq      <= 1'b1;
                                    underrun <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_FCS: begin
                        if (stuff_now) begin
                            tx_bit <= 1'b0;
                        end else begin
                            tx_bit <= fcs_bit;
                            if (bcnt == CNT_W'(FCS_W - 1)) begin
                                st   <= ST_CLOSE;
                                bcnt <= '0;
                            end else begin
                                bcnt <= bcnt + 1'b1;
                            end
                        end
                    end
                    ST_CLOSE: begin
                        if (stuff_now) begin
                            tx_bit <= 1'b0;
                        end else if (bcnt == CNT_W'(FLAG_W)) begin
                            tx_bit <= 1'b1;
                            st     <= ST_IDLE;
                            bcnt   <= '0;
                        end else begin
                            tx_bit <= FLAG_PAT[bcnt[FLAG_IDX_W-1:0]];
                            bcnt   <= bcnt + 1'b1;
                        end
                    end
                    ST_ABORT: begin
                        tx_bit <= 1'b1;
                        if (bcnt == CNT_W'(ABORT_ONES - 1)) begin
                            st   <= ST_IDLE;
                            bcnt <= '0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/irtx_framer_chk.sv
module irtx_framer_chk
    import irtx_pkg::*;
#(
    parameter int STUFF_RUN = 5
) (
    input logic      clk,
    input logic      rst,
    input logic      enable,
    input logic      in_ready,
    input logic      bit_strobe,
    input logic      tx_bit,
    input logic      tx_frame,
    input logic      clr_underrun,
    input logic      underrun,
    input logic      irq,
    input tx_state_e st
);

    localparam int RW = $clog2(STUFF_RUN + 2);

    logic          strobe_q;
    logic          body_q;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            body_q   <= 1'b0;
            run      <= '0;
        end else begin
            strobe_q <= bit_strobe;
            body_q   <= (st == ST_BYTE) || (st == ST_FCS);
            if (strobe_q) begin
                if (body_q && tx_bit) begin
                    run <= (run == RW'(STUFF_RUN + 1)) ? run : run + 1'b1;
                end else begin
                    run <= '0;
                end
            end
        end
    end

    a_r1_idle_line: assert property (@(posedge clk) disable iff (rst)
        !tx_frame |-> tx_bit);

    a_r2_no_take_disabled: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !in_ready);

    a_r6_stuff_limit: assert property (@(posedge clk) disable iff (rst)
        run <= RW'(STUFF_RUN));

    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r11_irq_sets_status: assert property (@(posedge clk) disable iff (rst)
        irq |-> underrun);

    a_r11_status_sticky: assert property (@(posedge clk) disable iff (rst)
        (underrun && !clr_underrun) |=> underrun);

endmodule

bind irtx_framer irtx_framer_chk #(.STUFF_RUN(STUFF_RUN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .in_ready     (in_ready),
    .bit_strobe   (bit_strobe),
    .tx_bit       (tx_bit),
    .tx_frame     (tx_frame),
    .clr_underrun (clr_underrun),
    .underrun     (underrun),
    .irq          (irq),
    .st           (st)
);

// File: tb/test_irtx_framer.sv
`timescale 1ns/1ps
module test_irtx_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       ctrl_present = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       bit_strobe = 1'b0;
    logic       tx_bit;
    logic       tx_frame;
    logic       clr_underrun = 1'b0;
    logic       underrun;
    logic       irq;

    always #2.5 clk = ~clk;

    irtx_framer i_irtx_framer (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .ctrl_present (ctrl_present),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .in_ready     (in_ready),
        .bit_strobe   (bit_strobe),
        .tx_bit       (tx_bit),
        .tx_frame     (tx_frame),
        .clr_underrun (clr_underrun),
        .underrun     (underrun),
        .irq          (irq)
    );

    int  total = 0;
    int  fails = 0;
    bit  done = 0;
    bit  cap [0:1023];
    int  cap_n = 0;
    bit  cap_on = 0;
    int  irq_cnt = 0;
    bit  saw_frame = 0;

    logic [7:0] fb[$];
    bit         fl[$];
    bit         eq[$];

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bit_strobe = 1'b1;
            @(negedge clk);
            bit_strobe = 1'b0;
            if (cap_on && cap_n < 1024) begin
                cap[cap_n] = tx_bit;
                cap_n++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && irq) irq_cnt++;
        if (!rst && tx_frame) saw_frame = 1;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run hung (actual timeout, expected completion)");
            $display("  [TB] %0d tests run, %0d failed", total, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input bit l);
        in_data  = d;
        in_last  = l;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic make_exp(input bit aborted);
        bit body[$];
        bit stf[$];
        logic [15:0] c;
        int run;
        int nb;
        c = 16'hFFFF;
        eq.delete();
        nb = aborted ? 1 : fb.size();
        for (int i = 0; i < nb; i++)
            for (int j = 0; j < 8; j++) body.push_back(fb[i][j]);
        if (!aborted) begin
            foreach (body[i]) begin
                if (c[0] ^ body[i]) c = (c >> 1) ^ 16'h8408;
                else                c = c >> 1;
            end
            c = ~c;
            for (int j = 0; j < 16; j++) body.push_back(c[j]);
        end
        run = 0;
        foreach (body[i]) begin
            stf.push_back(body[i]);
            run = body[i] ? run + 1 : 0;
            if (run == 5) begin
                stf.push_back(1'b0);
                run = 0;
            end
        end
        for (int f = 0; f < 2; f++)
            for (int j = 0; j < 8; j++) eq.push_back(j != 0 && j != 7);
        foreach (stf[i]) eq.push_back(stf[i]);
        if (aborted) begin
            for (int j = 0; j < 8; j++) eq.push_back(1'b1);
        end else begin
            for (int j = 0; j < 8; j++) eq.push_back(j != 0 && j != 7);
        end
        for (int j = 0; j < 4; j++) eq.push_back(1'b1);
    endtask

    task automatic run_frame(input bit ctrl, input bit aborted, input string tag);
        int k;
        int bad;
        ctrl_present = ctrl;
        cap_n = 0;
        cap_on = 1;
        foreach (fb[i]) push(fb[i], aborted ? 1'b0 : fl[i]);
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (!tx_frame) @(negedge clk);
        while (tx_frame) @(negedge clk);
        repeat (24) @(negedge clk);
        cap_on = 0;
        make_exp(aborted);
        k = -1;
        bad = -1;
        for (int i = 0; i < cap_n; i++) begin
            if (cap[i] == 1'b0) begin
                k = i;
                break;
            end
        end
        total++;
        if (k < 0 || k + eq.size() > cap_n) begin
            fails++;
            $display("FAIL %s: captured bits actual %0d expected %0d", tag, cap_n, eq.size());
            return;
        end
        for (int i = 0; i < eq.size(); i++)
            if (bad < 0 && cap[k + i] != eq[i]) bad = i;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: bit %0d actual %0d expected %0d", tag, bad, cap[k + bad], eq[bad]);
        end
    endtask

    initial begin
        int irq0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(tx_bit == 1'b1,   "R1 tx_bit after reset", tx_bit, 1);
        chk(tx_frame == 1'b0, "R1 tx_frame after reset", tx_frame, 0);
        chk(underrun == 1'b0, "R1 underrun after reset", underrun, 0);
        chk(irq == 1'b0,      "R1 irq after reset", irq, 0);

        // R2: disabled, a byte offered is never taken
        in_data = 8'hA5; in_last = 1'b1; in_valid = 1'b1;
        saw_frame = 0;
        repeat (80) begin
            @(negedge clk);
            if (in_ready) break;
        end
        chk(in_ready == 1'b0, "R2 in_ready while disabled", in_ready, 0);
        chk(saw_frame == 1'b0, "R2 frame started while disabled", saw_frame, 0);
        chk(tx_bit == 1'b1, "R2 line while disabled", tx_bit, 1);
        in_valid = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        // R1: holding stage empty after reset, so enabling with no valid starts nothing
        saw_frame = 0;
        repeat (40) @(negedge clk);
        chk(saw_frame == 1'b0, "R1 no frame from empty hold", saw_frame, 0);

        // R3 R5 R6 R7 R9: address-only sweep over every byte value
        for (int a = 0; a < 256; a++) begin
            fb.delete(); fl.delete();
            fb.push_back(a[7:0]); fl.push_back(1'b1);
            run_frame(1'b0, 1'b0, $sformatf("R9/R5/R6 address-only 0x%02h", a));
        end

        // R4: address, control, data
        fb = '{8'h3C, 8'h81, 8'h10, 8'h20, 8'h30}; fl = '{0, 0, 0, 0, 1};
        run_frame(1'b1, 1'b0, "R4 frame with control field");
        fb = '{8'h3C, 8'h81, 8'h10}; fl = '{0, 0, 1};
        run_frame(1'b0, 1'b0, "R4 frame without control field");

        // R6: stuffing across byte boundaries and flag-valued data
        fb = '{8'hFF, 8'hFF, 8'hFF, 8'hFF}; fl = '{0, 0, 0, 1};
        run_frame(1'b0, 1'b0, "R6 all-ones bytes");
        fb = '{8'h7E, 8'h7E, 8'h7E}; fl = '{0, 0, 1};
        run_frame(1'b0, 1'b0, "R6 flag-valued bytes");
        fb = '{8'h00, 8'h00, 8'h00}; fl = '{0, 0, 1};
        run_frame(1'b1, 1'b0, "R5 zero bytes");
        fb.delete(); fl.delete();
        for (int i = 0; i < 8; i++) begin
            fb.push_back(8'(i * 37 + 5)); fl.push_back(i == 7);
        end
        run_frame(1'b0, 1'b0, "R5 counting bytes");

        // R8: end marker on address ignored when control field present
        fb = '{8'h5A, 8'hC3}; fl = '{1, 1};
        run_frame(1'b1, 1'b0, "R8 early end marker on address");

        chk(irq_cnt == 0, "R10 irq count after complete frames", irq_cnt, 0);
        chk(underrun == 1'b0, "R10 underrun after complete frames", underrun, 0);

        // R10: underrun after address byte
        irq0 = irq_cnt;
        fb = '{8'h35}; fl = '{0};
        run_frame(1'b0, 1'b1, "R10 abort tail after underrun");
        chk(irq_cnt - irq0 == 1, "R10 irq pulses on abort", irq_cnt - irq0, 1);
        chk(underrun == 1'b1, "R11 underrun set", underrun, 1);
        repeat (30) @(negedge clk);
        chk(underrun == 1'b1, "R11 underrun held", underrun, 1);
        clr_underrun = 1'b1;
        @(negedge clk);
        clr_underrun = 1'b0;
        chk(underrun == 1'b0, "R11 underrun cleared", underrun, 0);

        // R10: after abort, a normal frame still runs
        fb = '{8'h96, 8'h01}; fl = '{0, 1};
        run_frame(1'b0, 1'b0, "R10 frame after abort");
        chk(underrun == 1'b0, "R11 underrun stays clear", underrun, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

endmodule